// File: doc/BRIEF.md
# Affine-Gap Local Alignment Scoring Array

This block scores the best local alignment between a short query sequence and each sequence of a database stream. It is a linear chain of identical scoring elements. Each element holds one query character, and one row of the dynamic-programming matrix is computed in each element. Database characters enter the first element one per cycle and move down the chain one element per cycle, so a whole anti-diagonal of the matrix is computed at once. A running maximum travels with each character. When the last character of a database sequence leaves the final element, that maximum is the sequence's best score, and it is presented at the output.

Software sets up the array before streaming starts. It writes one query character into each element through an element-indexed load port and marks unused elements as inactive. It fills a 32×32 table of signed substitution scores. It writes a gap-open and a gap-extend penalty. Characters use 5-bit codes, which cover the 20 amino acids and the 4 nucleotides. Both stream edges use valid/ready handshakes. When the output holds a score the consumer has not taken, the whole array freezes. Idle input cycles pass through the chain as empty slots and leave every element unchanged.

Top module: `sw_array`

## Requirements
- R1: After reset, `out_valid` is 0 and `in_ready` is 1.
- R2: The score for a database sequence is the largest H over the whole matrix. H = max(0, H_diag + S, E, F), with row 0 and column 0 of the matrix equal to 0. With match +2, mismatch −1 and both penalties 1, query AGCACACA against database ACACACTAG scores 12.
- R3: S is read from the table entry whose 10-bit address is {query code, database code}, with the query code in bits 9:5 and the database code in bits 4:0. Each entry is a signed 8-bit value, so the table need not be symmetric.
- R4: Element k holds the query character at position k, loaded through `qry_idx`. An element loaded with `qry_use`=0 contributes H=E=F=0. The query therefore occupies elements 0 to n−1 in order, with n the query length.
- R5: `in_last` marks the final character of a database sequence. Exactly one score is produced per sequence, and the state of one sequence does not carry into the next.
- R6: With `out_ready` held high, `out_valid` for a sequence rises on the NUM_PE-th rising edge after the edge that accepts its last character. This holds whatever the query length.
- R7: While `out_valid` is 1 and `out_ready` is 0, `in_ready` is 0, `out_score` holds its value, and no element changes state.
- R8: H saturates at 2^(SCORE_W−1)−1, and that value is never exceeded.
- R9: Cycles with `in_valid` low do not alter any score.
- R10: A gap costs `pen_open` for its first character and `pen_ext` for each further character. Both are unsigned and take effect when `pen_we` is pulsed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sub_we | input | 1 | Substitution table write strobe |
| sub_addr | input | 10 | {query code, database code} |
| sub_val | input | 8 | Signed substitution score |
| qry_we | input | 1 | Query element write strobe |
| qry_idx | input | $clog2(NUM_PE) | Element index |
| qry_code | input | 5 | Query character code |
| qry_use | input | 1 | Element is part of the query |
| pen_we | input | 1 | Penalty write strobe |
| pen_open | input | 8 | Cost of a gap's first character |
| pen_ext | input | 8 | Cost of each further gap character |
| in_valid | input | 1 | Database character present |
| in_ready | output | 1 | Array accepts a character this cycle |
| in_code | input | 5 | Database character code |
| in_last | input | 1 | Final character of its sequence |
| out_valid | output | 1 | Score present |
| out_ready | input | 1 | Consumer takes the score |
| out_score | output | SCORE_W | Best local score of one sequence |

## Verification
The hardest case to reach is a freeze that lands while several sequences are inside the chain at once. The bench causes it with back-to-back sequences, idle input slots and a periodic `out_ready` pattern, all at the same time. It then compares `out_valid`, `out_score` and `in_ready` against a cycle model on every clock. Saturation needs a long diagonal run of large scores, so the bench builds the array with a narrow score width and a table entry of +127 to reach it. Element and sequence boundaries are exercised with a short query, a one-character sequence and an asymmetric table.

// File: rtl/sw_pkg.sv
package sw_pkg;
  localparam int CODE_W = 5;
  localparam int SUB_W  = 8;
  localparam int PEN_W  = 8;
  localparam int TBL_AW = 2 * CODE_W;
endpackage

// File: rtl/sw_subst_table.sv
module sw_subst_table import sw_pkg::*; #(
  parameter int NUM_RD = 16
) (
  input  logic                               clk,
  input  logic                               we,
  input  logic [TBL_AW-1:0]                  waddr,
  input  logic signed [SUB_W-1:0]            wdata,
  input  logic [NUM_RD-1:0][TBL_AW-1:0]      raddr,
  output logic [NUM_RD-1:0][SUB_W-1:0]       rdata
);
  localparam int DEPTH = 1 << TBL_AW;

  logic [SUB_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  for (genvar k = 0; k < NUM_RD; k++) begin : g_rd
    assign rdata[k] = mem[raddr[k]];
  end
endmodule

// File: rtl/sw_cell.sv
module sw_cell import sw_pkg::*; #(
  parameter int SCORE_W = 16
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     adv,
  input  logic                     cfg_we,
  input  logic [CODE_W-1:0]        cfg_code,
  input  logic                     cfg_use,
  input  logic [PEN_W-1:0]         gap_open,
  input  logic [PEN_W-1:0]         gap_ext,
  input  logic                     in_v,
  input  logic                     in_last,
  input  logic [CODE_W-1:0]        in_code,
  input  logic [SCORE_W-1:0]       in_h,
  input  logic [SCORE_W-1:0]       in_f,
  input  logic [SCORE_W-1:0]       in_mx,
  input  logic [SUB_W-1:0]         sub,
  output logic [CODE_W-1:0]        q_code,
  output logic                     out_v,
  output logic                     out_last,
  output logic [CODE_W-1:0]        out_code,
  output logic [SCORE_W-1:0]       out_h,
  output logic [SCORE_W-1:0]       out_f,
  output logic [SCORE_W-1:0]       out_mx
);
  localparam int IW = SCORE_W + 2;
  localparam logic signed [IW-1:0] ZERO = '0;
  localparam logic signed [IW-1:0] SMAX = {3'b000, {(SCORE_W-1){1'b1}}};
  localparam logic [SCORE_W-1:0] SMAX_U = {1'b0, {(SCORE_W-1){1'b1}}};

  logic                q_use;
  logic [SCORE_W-1:0]  h_left, e_left, diag, rowmax;
  logic signed [IW-1:0] op, ex, hl, el, hu, fu, dg, e_n, f_n, h_n, rm_n, mx_n;

  function automatic logic signed [IW-1:0] max2(input logic signed [IW-1:0] a,
                                                input logic signed [IW-1:0] b);
    return (a > b) ? a : b;
  endfunction

  function automatic logic signed [IW-1:0] ext(input logic [SCORE_W-1:0] v);
    return {2'b00, v};
  endfunction

  always_comb begin
    op = {{(IW-PEN_W){1'b0}}, gap_open};
    ex = {{(IW-PEN_W){1'b0}}, gap_ext};
    hl = ext(h_left);
    el = ext(e_left);
    hu = ext(in_h);
    fu = ext(in_f);
    dg = ext(diag) + {{(IW-SUB_W){sub[SUB_W-1]}}, sub};
    e_n = max2(max2(hl - op, el - ex), ZERO);
    f_n = max2(max2(hu - op, fu - ex), ZERO);
    h_n = max2(max2(dg, e_n), max2(f_n, ZERO));
    if (h_n > SMAX) h_n = SMAX;
    if (!q_use) begin
      h_n = ZERO;
      e_n = ZERO;
      f_n = ZERO;
    end
    rm_n = max2(ext(rowmax), h_n);
    mx_n = max2(ext(in_mx), rm_n);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      q_code <= '0;
      q_use  <= 1'b0;
    end else if (cfg_we) begin
      q_code <= cfg_code;
      q_use  <= cfg_use;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_v    <= 1'b0;
      out_last <= 1'b0;
      out_code <= '0;
      out_h    <= '0;
      out_f    <= '0;
      out_mx   <= '0;
      h_left   <= '0;
      e_left   <= '0;
      diag     <= '0;
      rowmax   <= '0;
    end else if (adv) begin
      out_v <= in_v;
      if (in_v) begin
        out_last <= in_last;
        out_code <= in_code;
        out_h    <= h_n[SCORE_W-1:0];
        out_f    <= f_n[SCORE_W-1:0];
        out_mx   <= mx_n[SCORE_W-1:0];
        if (in_last) begin
          h_left <= '0;
          e_left <= '0;
          diag   <= '0;
          rowmax <= '0;
        end else begin
          h_left <= h_n[SCORE_W-1:0];
          e_left <= e_n[SCORE_W-1:0];
          diag   <= in_h;
          rowmax <= rm_n[SCORE_W-1:0];
        end
      end
    end
  end

  // R8
  score_cap_chk: assert property (@(posedge clk) disable iff (rst)
    out_v |-> (out_h <= SMAX_U) && (out_mx <= SMAX_U));

  // R2
  max_cover_chk: assert property (@(posedge clk) disable iff (rst)
    out_v |-> (out_mx >= out_h));

  // R7
  freeze_chk: assert property (@(posedge clk) disable iff (rst)
    !adv |=> $stable(out_v) && $stable(out_h) && $stable(out_mx));
endmodule

// File: rtl/sw_array.sv
module sw_array import sw_pkg::*; #(
  parameter int NUM_PE  = 16,
  parameter int SCORE_W = 16,
  localparam int IDX_W  = $clog2(NUM_PE)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 sub_we,
  input  logic [TBL_AW-1:0]    sub_addr,
  input  logic [SUB_W-1:0]     sub_val,
  input  logic                 qry_we,
  input  logic [IDX_W-1:0]     qry_idx,
  input  logic [CODE_W-1:0]    qry_code,
  input  logic                 qry_use,
  input  logic                 pen_we,
  input  logic [PEN_W-1:0]     pen_open,
  input  logic [PEN_W-1:0]     pen_ext,
  input  logic                 in_valid,
  output logic                 in_ready,
  input  logic [CODE_W-1:0]    in_code,
  input  logic                 in_last,
  output logic                 out_valid,
  input  logic                 out_ready,
  output logic [SCORE_W-1:0]   out_score
);
  logic                adv;
  logic [PEN_W-1:0]    g_open, g_ext;
  logic                ch_v    [NUM_PE+1];
  logic                ch_last [NUM_PE+1];
  logic [CODE_W-1:0]   ch_code [NUM_PE+1];
  logic [SCORE_W-1:0]  ch_h    [NUM_PE+1];
  logic [SCORE_W-1:0]  ch_f    [NUM_PE+1];
  logic [SCORE_W-1:0]  ch_mx   [NUM_PE+1];
  logic [NUM_PE-1:0][TBL_AW-1:0] rd_addr;
  logic [NUM_PE-1:0][SUB_W-1:0]  rd_data;
  logic [CODE_W-1:0]   qc      [NUM_PE];
  logic                unused_tail;

  assign adv      = !out_valid || out_ready;
  assign in_ready = adv;

  assign ch_v[0]    = in_valid;
  assign ch_last[0] = in_last;
  assign ch_code[0] = in_code;
  assign ch_h[0]    = '0;
  assign ch_f[0]    = '0;
  assign ch_mx[0]   = '0;
  assign unused_tail = &{1'b0, ch_code[NUM_PE], ch_f[NUM_PE], ch_h[NUM_PE]};

  always_ff @(posedge clk) begin
    if (rst) begin
      g_open <= '0;
      g_ext  <= '0;
    end else if (pen_we) begin
      g_open <= pen_open;
      g_ext  <= pen_ext;
    end
  end

  sw_subst_table #(.NUM_RD(NUM_PE)) u_tbl (
    .clk(clk), .we(sub_we), .waddr(sub_addr), .wdata(sub_val),
    .raddr(rd_addr), .rdata(rd_data)
  );

  for (genvar k = 0; k < NUM_PE; k++) begin : g_pe
    assign rd_addr[k] = {qc[k], ch_code[k]};
    sw_cell #(.SCORE_W(SCORE_W)) u_cell (
      .clk(clk), .rst(rst), .adv(adv),
      .cfg_we(qry_we && (qry_idx == IDX_W'(k))),
      .cfg_code(qry_code), .cfg_use(qry_use),
      .gap_open(g_open), .gap_ext(g_ext),
      .in_v(ch_v[k]), .in_last(ch_last[k]), .in_code(ch_code[k]),
      .in_h(ch_h[k]), .in_f(ch_f[k]), .in_mx(ch_mx[k]),
      .sub(rd_data[k]), .q_code(qc[k]),
      .out_v(ch_v[k+1]), .out_last(ch_last[k+1]), .out_code(ch_code[k+1]),
      .out_h(ch_h[k+1]), .out_f(ch_f[k+1]), .out_mx(ch_mx[k+1])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_score <= '0;
    end else if (adv) begin
      out_valid <= ch_v[NUM_PE] && ch_last[NUM_PE];
      if (ch_v[NUM_PE] && ch_last[NUM_PE]) out_score <= ch_mx[NUM_PE];
    end
  end

  // R7
  out_hold_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid && !out_ready |=> out_valid && $stable(out_score));

  // R7
  in_block_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid && !out_ready |-> !in_ready);

  // R5
  one_score_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid && out_ready && !(ch_v[NUM_PE] && ch_last[NUM_PE]) |=> !out_valid);
endmodule

// File: tb/sw_array_test.sv
module sw_array_test;
  localparam int NPE = 8;
  localparam int SW  = 10;
  localparam int SMAX = 511;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst = 1'b1;
  logic sub_we = 1'b0; logic [9:0] sub_addr = '0; logic [7:0] sub_val = '0;
  logic qry_we = 1'b0; logic [2:0] qry_idx = '0; logic [4:0] qry_code = '0; logic qry_use = 1'b0;
  logic pen_we = 1'b0; logic [7:0] pen_open = '0; logic [7:0] pen_ext = '0;
  logic in_valid = 1'b0; logic in_ready; logic [4:0] in_code = '0; logic in_last = 1'b0;
  logic out_valid; logic out_ready = 1'b1; logic [SW-1:0] out_score;

  sw_array #(.NUM_PE(NPE), .SCORE_W(SW)) uut (
    .clk(clk), .rst(rst), .sub_we(sub_we), .sub_addr(sub_addr), .sub_val(sub_val),
    .qry_we(qry_we), .qry_idx(qry_idx), .qry_code(qry_code), .qry_use(qry_use),
    .pen_we(pen_we), .pen_open(pen_open), .pen_ext(pen_ext),
    .in_valid(in_valid), .in_ready(in_ready), .in_code(in_code), .in_last(in_last),
    .out_valid(out_valid), .out_ready(out_ready), .out_score(out_score)
  );

  int total = 0, bad = 0;
  string req = "R2";
  int sub_t[1024];
  int qry[NPE];
  bit quse[NPE];
  int g_open = 0, g_ext = 0;
  int drv_score = 0;
  bit mv[NPE]; bit ml[NPE]; int ms[NPE];
  bit m_ov = 0; int m_sc = 0;
  int got[$];
  int rdy_mode = 0;
  int gap_mode = 0;
  int cyc = 0, last_acc = -1, lat = -1;
  bit prev_ov = 0;

  task automatic chk(bit ok, string r, int act, int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", r, act, exp);
    end
  endtask

  function automatic int imax(int a, int b);
    return (a > b) ? a : b;
  endfunction

  function automatic int ref_score(int db[$]);
    int hp[NPE+1]; int ep[NPE+1]; int hc[NPE+1]; int ec[NPE+1];
    int best = 0;
    for (int i = 0; i <= NPE; i++) begin hp[i] = 0; ep[i] = 0; end
    for (int j = 0; j < db.size(); j++) begin
      int fc = 0;
      hc[0] = 0; ec[0] = 0;
      for (int i = 1; i <= NPE; i++) begin
        if (!quse[i-1]) begin
          hc[i] = 0; ec[i] = 0; fc = 0;
        end else begin
          int e, f, h;
          e = imax(imax(hp[i] - g_open, ep[i] - g_ext), 0);
          f = imax(imax(hc[i-1] - g_open, fc - g_ext), 0);
          h = imax(imax(hp[i-1] + sub_t[qry[i-1]*32 + db[j]], 0), imax(e, f));
          if (h > SMAX) h = SMAX;
          hc[i] = h; ec[i] = e; fc = f;
          best = imax(best, h);
        end
      end
      for (int i = 0; i <= NPE; i++) begin hp[i] = hc[i]; ep[i] = ec[i]; end
    end
    return best;
  endfunction

  // cycle model of the stream and its per-clock comparison
  always @(posedge clk) begin
    bit adv;
    cyc++;
    if (rst) begin
      m_ov = 0;
      for (int k = 0; k < NPE; k++) mv[k] = 0;
    end else begin
      adv = !m_ov || out_ready;
      if (out_valid && out_ready) got.push_back(out_score);
      if (in_valid && in_ready && in_last) last_acc = cyc;
      if (adv) begin
        m_ov = mv[NPE-1] && ml[NPE-1];
        if (m_ov) m_sc = ms[NPE-1];
        for (int k = NPE-1; k > 0; k--) begin
          mv[k] = mv[k-1]; ml[k] = ml[k-1]; ms[k] = ms[k-1];
        end
        mv[0] = in_valid; ml[0] = in_last; ms[0] = drv_score;
      end
    end
    #2;
    if (!rst) begin
      chk(out_valid == m_ov, {req, " out_valid"}, out_valid, m_ov);
      if (m_ov) chk(out_score == m_sc, {req, " out_score"}, out_score, m_sc);
      if (out_valid && !prev_ov) lat = cyc - last_acc;
    end
    prev_ov = out_valid;
  end

  always @(negedge clk) begin
    if (rdy_mode == 0) out_ready <= 1'b1;
    else out_ready <= (cyc % 3) != 0;
  end

  task automatic wsub(int a, int b, int v);
    @(negedge clk);
    sub_we = 1'b1; sub_addr = 10'(a*32 + b); sub_val = 8'(v);
    sub_t[a*32 + b] = v;
  endtask

  task automatic fill_table(int m, int mm);
    for (int a = 0; a < 32; a++)
      for (int b = 0; b < 32; b++) wsub(a, b, (a == b) ? m : mm);
    @(negedge clk); sub_we = 1'b0;
  endtask

  task automatic set_query(int q[$]);
    for (int k = 0; k < NPE; k++) begin
      @(negedge clk);
      qry_we = 1'b1; qry_idx = 3'(k);
      qry_use = (k < q.size());
      qry_code = (k < q.size()) ? 5'(q[k]) : 5'd0;
      quse[k] = (k < q.size());
      qry[k] = (k < q.size()) ? q[k] : 0;
    end
    @(negedge clk); qry_we = 1'b0;
  endtask

  task automatic set_pen(int o, int e);
    @(negedge clk);
    pen_we = 1'b1; pen_open = 8'(o); pen_ext = 8'(e);
    g_open = o; g_ext = e;
    @(negedge clk); pen_we = 1'b0;
  endtask

  task automatic send(int db[$]);
    int sc = ref_score(db);
    for (int k = 0; k < db.size(); k++) begin
      bit acc;
      if (gap_mode != 0 && (k % 3) == 1) begin
        @(negedge clk); in_valid = 1'b0;
      end
      do begin
        @(negedge clk);
        in_valid = 1'b1; in_code = 5'(db[k]);
        in_last = (k == db.size() - 1);
        drv_score = sc;
        #1;
        acc = in_ready;
        chk(in_ready == (!m_ov || out_ready), "R7 in_ready", in_ready, !m_ov || out_ready);
      end while (!acc);
    end
    @(negedge clk); in_valid = 1'b0; in_last = 1'b0;
  endtask

  task automatic drain();
    repeat (3 * NPE + 12) @(negedge clk);
  endtask

  task automatic expect_scores(string r, int exp[$]);
    chk(got.size() == exp.size(), {r, " score count"}, got.size(), exp.size());
    for (int k = 0; k < exp.size() && k < got.size(); k++)
      chk(got[k] == exp[k], {r, " score"}, got[k], exp[k]);
    got.delete();
  endtask

  task automatic finish_all();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    #(8 * 150000);
    bad++;
    $display("FAIL watchdog expired actual=0 expected=1");
    finish_all();
  end

  initial begin
    int e[$];
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk); #1;
    // R1 reset state
    chk(out_valid == 1'b0, "R1 out_valid", out_valid, 0);
    chk(in_ready == 1'b1, "R1 in_ready", in_ready, 1);

    // R2 worked example: A=0 C=1 G=2 T=3
    fill_table(2, -1);
    set_pen(1, 1);
    set_query('{0, 2, 1, 0, 1, 0, 1, 0});
    chk(ref_score('{0, 1, 0, 1, 0, 1, 3, 0, 2}) == 12, "R2 model example", ref_score('{0, 1, 0, 1, 0, 1, 3, 0, 2}), 12);
    req = "R2";
    send('{0, 1, 0, 1, 0, 1, 3, 0, 2});
    drain();
    expect_scores("R2", '{12});

    // R6 latency with full query
    req = "R6";
    send('{0, 2});
    drain();
    chk(lat == NPE, "R6 latency full query", lat, NPE);
    got.delete();

    // R10 affine penalties
    req = "R10";
    set_pen(3, 1);
    e.delete();
    send('{0, 2, 1, 3, 3, 3, 0, 1, 0}); e.push_back(ref_score('{0, 2, 1, 3, 3, 3, 0, 1, 0}));
    send('{0, 2, 1, 0, 1, 0, 1, 0});    e.push_back(ref_score('{0, 2, 1, 0, 1, 0, 1, 0}));
    send('{0, 2, 1, 3, 0, 1, 0, 1, 0}); e.push_back(ref_score('{0, 2, 1, 3, 0, 1, 0, 1, 0}));
    drain();
    expect_scores("R10", e);

    // R5 back-to-back sequences, one of length one
    req = "R5";
    e.delete();
    send('{0, 1, 0, 1, 0, 1}); e.push_back(ref_score('{0, 1, 0, 1, 0, 1}));
    send('{3});               e.push_back(ref_score('{3}));
    send('{2, 1});            e.push_back(ref_score('{2, 1}));
    drain();
    expect_scores("R5", e);
    chk(e[1] == 0, "R5 isolated short sequence", e[1], 0);

    // R4 short query, unused elements
    req = "R4";
    set_pen(1, 1);
    set_query('{1, 0, 2});
    e.delete();
    send('{1, 0, 2, 1, 0, 2}); e.push_back(ref_score('{1, 0, 2, 1, 0, 2}));
    drain();
    expect_scores("R4", e);
    chk(e[0] == 6, "R4 short query score", e[0], 6);
    send('{1, 0});
    drain();
    chk(lat == NPE, "R6 latency short query", lat, NPE);
    got.delete();

    // R3 asymmetric table: S(query G, db T)=5, S(query T, db G)=-4
    req = "R3";
    wsub(2, 3, 5); wsub(3, 2, -4);
    @(negedge clk); sub_we = 1'b0;
    set_query('{2});
    e.delete();
    send('{3}); e.push_back(5);
    set_query('{3});
    send('{2}); e.push_back(0);
    drain();
    expect_scores("R3", e);

    // R7 and R9: backpressure and idle slots together
    req = "R9";
    set_query('{0, 2, 1, 0, 1, 0, 1, 0});
    set_pen(2, 1);
    rdy_mode = 1; gap_mode = 1;
    e.delete();
    for (int r = 0; r < 5; r++) begin
      int db[$];
      for (int k = 0; k < 4 + r; k++) db.push_back((k * 3 + r) % 4);
      send(db);
      e.push_back(ref_score(db));
    end
    drain();
    expect_scores("R9", e);
    rdy_mode = 0; gap_mode = 0;

    // R8 saturation
    req = "R8";
    wsub(7, 7, 127);
    @(negedge clk); sub_we = 1'b0;
    set_query('{7, 7, 7, 7, 7, 7, 7, 7});
    send('{7, 7, 7, 7, 7, 7, 7, 7});
    drain();
    expect_scores("R8", '{SMAX});

    finish_all();
  end
endmodule